// File: doc/BRIEF.md
# Nonvolatile Shadow Store/Recall Controller

This block is a byte-wide static RAM paired with a second, nonvolatile-style shadow array of the same size. A controller copies data between them. A STORE writes every SRAM word into the shadow array. A RECALL writes every shadow word back into the SRAM. Each transfer handles one address per clock, so a transfer of either kind takes exactly one cycle per word.

A STORE can start in three ways: supply power dropping, a falling edge on an active-low store request pin, or a software unlock made of host reads. A RECALL starts when power returns, or through the software unlock ending on its recall address. While a transfer runs, an active-low busy flag is driven low and the host port is shut. Writes have no effect, reads return nothing and do not advance the unlock matcher. The standby indication stays low until the transfer is done. A saturating wear counter records how many STOREs have completed. The 8K x 8 organisation uses `ADDR_W = 13`. The default is a smaller 1K depth so that elaboration stays light.

Top module: `nvs_shadow_ram`

## Requirements
- R1: When the port is idle, a write (`ce_i`=1, `we_i`=1) stores `wdata_i` at `addr_i`. A read (`ce_i`=1, `we_i`=0) presents the word on `rdata_o` one cycle later, with `rvalid_o`=1 in that cycle. Out of reset, `busy_n_o`=1, `rvalid_o`=0, `wear_o`=0.
- R2: A falling edge of `pwr_ok_i` starts a STORE that copies all 2^ADDR_W SRAM words into the shadow array.
- R3: A rising edge of `pwr_ok_i` starts a RECALL that copies the whole shadow array into the SRAM. `pwr_ok_i` already high when reset is released counts as a rising edge.
- R4: A falling edge of `store_req_n_i` starts a STORE.
- R5: The software unlock is six accepted host reads in consecutive accesses.
  - The first five addresses are 0x0A5, 0x35A, 0x2C3, 0x13C and 0x2A1, in that order.
  - A sixth read of 0x1E0 starts a STORE. A sixth read of 0x21F starts a RECALL.
  - Any other read restarts the match. A read of 0x0A5 counts as the first step.
  - Any accepted write clears the match.
- R6: `busy_n_o` goes low in the cycle after the starting edge and stays low for exactly 2^ADDR_W cycles.
- R7: While `busy_n_o`=0, host writes have no effect on memory, reads give `rvalid_o`=0, and neither advances the unlock.
- R8: A STORE or RECALL request arriving while a transfer runs is dropped. It is not queued.
- R9: If a STORE source and a RECALL source fire in the same cycle, the STORE runs.
- R10: `wear_o` increments by one when a STORE completes, never on a RECALL, and saturates at `WEAR_MAX`.
- R11: `standby_o` is 1 only when `ce_i`=0 and no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok_i | input | 1 | Supply-good indication; fall = store, rise = recall |
| store_req_n_i | input | 1 | Active-low hardware store request |
| ce_i | input | 1 | Host chip enable |
| we_i | input | 1 | Host write enable |
| addr_i | input | ADDR_W | Host word address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Host read data |
| rvalid_o | output | 1 | Read data valid |
| busy_n_o | output | 1 | Low while a transfer runs |
| standby_o | output | 1 | Low-power standby permitted |
| wear_o | output | WEAR_W | Completed-STORE count, saturating |

## Verification
The bench hits the port during a STORE with a write, a read and a second store request. A design that let the host through would change address 5 or raise `rvalid_o`. A design that queued the request would run a second transfer and bump the wear count twice. The unlock is probed with one off-sequence read and one interleaved write before the final address. A matcher that failed to reset would start a transfer there.

The same-cycle collision of a software recall with a hardware store checks that the SRAM contents survive. A design that let recall win would overwrite them from the shadow array. The power-fail STORE after three completed STOREs checks the saturating counter, which a wrapping counter would fail.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      NVS_IDLE   = 2'd0,
      NVS_STORE  = 2'd1,
      NVS_RECALL = 2'd2
   } nvs_state_e;

   localparam int UNLOCK_STEPS = 5;   // prefix reads before the selecting read

   // Unlock table: entries 0..4 are the prefix, 5 selects store, 6 selects recall.
   function automatic logic [15:0] unlock_addr(input int idx);
      case (idx)
         0:       return 16'h00A5;
         1:       return 16'h035A;
         2:       return 16'h02C3;
         3:       return 16'h013C;
         4:       return 16'h02A1;
         5:       return 16'h01E0;
         6:       return 16'h021F;
         default: return 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire_i,
   input  logic              wr_fire_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              sw_store_o,
   output logic              sw_recall_o
);
   import nvs_pkg::*;

   localparam logic [2:0] LAST_STEP = 3'(UNLOCK_STEPS);

   logic [ADDR_W-1:0] seq_tab [8];
   logic [2:0]        step_q;

   for (genvar g = 0; g < 8; g++) begin : g_tab
      localparam logic [15:0] RAW = unlock_addr(g);
      assign seq_tab[g] = RAW[ADDR_W-1:0];
   end

   always_comb begin
      sw_store_o  = rd_fire_i && (step_q == LAST_STEP) && (addr_i == seq_tab[5]);
      sw_recall_o = rd_fire_i && (step_q == LAST_STEP) && (addr_i == seq_tab[6]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (wr_fire_i) begin
         step_q <= '0;
      end else if (rd_fire_i) begin
         if (step_q < LAST_STEP && addr_i == seq_tab[step_q])
            step_q <= step_q + 3'd1;
         else if (addr_i == seq_tab[0])
            step_q <= 3'd1;
         else
            step_q <= '0;
      end
   end

   // R5: matcher never runs past the selecting step
   a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST_STEP);
   // R5: an accepted write clears any partial match
   a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i |=> (step_q == 3'd0));
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer #(
   parameter int ADDR_W   = 10,
   parameter int WEAR_MAX = 1000000,
   parameter int WEAR_W   = $clog2(WEAR_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_ok_i,
   input  logic              store_req_n_i,
   input  logic              sw_store_i,
   input  logic              sw_recall_i,
   output logic              busy_o,
   output logic              store_act_o,
   output logic              recall_act_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [WEAR_W-1:0] wear_o
);
   import nvs_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_PTR = {ADDR_W{1'b1}};
   localparam logic [WEAR_W-1:0] WEAR_TOP = WEAR_W'(WEAR_MAX);

   nvs_state_e        state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [WEAR_W-1:0] wear_q;
   logic              pwr_q, req_q;
   logic              want_store, want_recall;

   always_comb begin
      want_store  = (pwr_q && !pwr_ok_i) || (req_q && !store_req_n_i) || sw_store_i;
      want_recall = (!pwr_q && pwr_ok_i) || sw_recall_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 1'b0;
         req_q <= 1'b1;
      end else begin
         pwr_q <= pwr_ok_i;
         req_q <= store_req_n_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= NVS_IDLE;
         ptr_q   <= '0;
         wear_q  <= '0;
      end else if (state_q == NVS_IDLE) begin
         ptr_q <= '0;
         if (want_store)       state_q <= NVS_STORE;
         else if (want_recall) state_q <= NVS_RECALL;
      end else begin
         ptr_q <= ptr_q + 1'b1;
         if (ptr_q == LAST_PTR) begin
            state_q <= NVS_IDLE;
            if (state_q == NVS_STORE && wear_q < WEAR_TOP) wear_q <= wear_q + 1'b1;
         end
      end
   end

   assign busy_o       = (state_q != NVS_IDLE);
   assign store_act_o  = (state_q == NVS_STORE);
   assign recall_act_o = (state_q == NVS_RECALL);
   assign ptr_o        = ptr_q;
   assign wear_o       = wear_q;

   // R8: a running transfer keeps its kind until the last address
   a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != NVS_IDLE && ptr_q != LAST_PTR) |=> (state_q == $past(state_q)));
   // R6: the walker advances one address per cycle
   a_r6_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != NVS_IDLE && ptr_q != LAST_PTR) |=> (ptr_q == $past(ptr_q) + 1'b1));
   // R9: store wins a same-cycle collision
   a_r9_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == NVS_IDLE && want_store && want_recall) |=> (state_q == NVS_STORE));
   // R10: wear only steps by one, only after a store
   a_r10_wear_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wear_q) |-> (wear_q == $past(wear_q) + 1'b1 && $past(state_q) == NVS_STORE));
   a_r10_wear_cap: assert property (@(posedge clk) disable iff (!rst_n)
      wear_q <= WEAR_TOP);
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              host_we_i,
   input  logic              host_re_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic              store_act_i,
   input  logic              recall_act_i,
   input  logic [ADDR_W-1:0] ptr_i
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] sram_mem   [DEPTH];
   logic [DATA_W-1:0] shadow_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (recall_act_i)   sram_mem[ptr_i] <= shadow_mem[ptr_i];
      else if (host_we_i) sram_mem[host_addr_i] <= host_wdata_i;
   end

   always_ff @(posedge clk) begin
      if (store_act_i) shadow_mem[ptr_i] <= sram_mem[ptr_i];
   end

   always_ff @(posedge clk) begin
      if (host_re_i) host_rdata_o <= sram_mem[host_addr_i];
   end

   // R7: host port is never enabled while a transfer owns the arrays
   a_r7_port_exclusive: assert property (@(posedge clk)
      (store_act_i || recall_act_i) |-> !(host_we_i || host_re_i));
endmodule

// File: rtl/nvs_shadow_ram.sv
module nvs_shadow_ram #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 8,
   parameter int WEAR_MAX = 1000000,
   parameter int WEAR_W   = $clog2(WEAR_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_ok_i,
   input  logic              store_req_n_i,
   input  logic              ce_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              busy_n_o,
   output logic              standby_o,
   output logic [WEAR_W-1:0] wear_o
);
   if (ADDR_W < 10 || ADDR_W > 16) begin : g_chk_addr
      $error("nvs_shadow_ram: ADDR_W must be 10..16 to hold the unlock addresses");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("nvs_shadow_ram: DATA_W must be positive");
   end
   if (WEAR_MAX < 1) begin : g_chk_wear
      $error("nvs_shadow_ram: WEAR_MAX must be positive");
   end

   logic              busy, store_act, recall_act, sw_store, sw_recall;
   logic              rd_fire, wr_fire;
   logic [ADDR_W-1:0] ptr;

   assign rd_fire = ce_i && !we_i && !busy;
   assign wr_fire = ce_i &&  we_i && !busy;

   nvs_unlock #(.ADDR_W(ADDR_W)) unlock_i (
      .clk(clk), .rst_n(rst_n), .rd_fire_i(rd_fire), .wr_fire_i(wr_fire),
      .addr_i(addr_i), .sw_store_o(sw_store), .sw_recall_o(sw_recall));

   nvs_sequencer #(.ADDR_W(ADDR_W), .WEAR_MAX(WEAR_MAX), .WEAR_W(WEAR_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok_i), .store_req_n_i(store_req_n_i),
      .sw_store_i(sw_store), .sw_recall_i(sw_recall), .busy_o(busy),
      .store_act_o(store_act), .recall_act_o(recall_act), .ptr_o(ptr), .wear_o(wear_o));

   nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
      .clk(clk), .host_we_i(wr_fire), .host_re_i(rd_fire), .host_addr_i(addr_i),
      .host_wdata_i(wdata_i), .host_rdata_o(rdata_o), .store_act_i(store_act),
      .recall_act_i(recall_act), .ptr_i(ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_o <= 1'b0;
      else        rvalid_o <= rd_fire;
   end

   assign busy_n_o  = !busy;
   assign standby_o = !ce_i && !busy;

   // R7: a read presented during a transfer never yields valid data
   a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n_o && ce_i && !we_i) |=> !rvalid_o);
   // R1: an idle read is answered in the next cycle
   a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n_o && ce_i && !we_i) |=> rvalid_o);
   // R11: no standby while a transfer is running
   a_r11_no_standby_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n_o |-> !standby_o);
endmodule

// File: tb/nvs_shadow_ram_tb.sv
module nvs_shadow_ram_tb_top;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 8;
   localparam int WEAR_MAX = 3;
   localparam int WEAR_W = $clog2(WEAR_MAX + 1);
   localparam int DEPTH = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_ok = 1'b0;
   logic store_req_n = 1'b1;
   logic ce = 1'b0;
   logic we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic rvalid, busy_n, standby;
   logic [WEAR_W-1:0] wear;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // unlock addresses as stated in R5
   logic [ADDR_W-1:0] pre [5] = '{10'h0A5, 10'h35A, 10'h2C3, 10'h13C, 10'h2A1};
   localparam logic [ADDR_W-1:0] SEL_STORE  = 10'h1E0;
   localparam logic [ADDR_W-1:0] SEL_RECALL = 10'h21F;

   always #2 clk = ~clk;

   nvs_shadow_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WEAR_MAX(WEAR_MAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .store_req_n_i(store_req_n),
      .ce_i(ce), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .rvalid_o(rvalid), .busy_n_o(busy_n), .standby_o(standby), .wear_o(wear));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      ce = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      ce = 1'b0; we = 1'b0;
   endtask

   task automatic host_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                            output logic v);
      ce = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      d = rdata; v = rvalid;
      ce = 1'b0;
   endtask

   task automatic measure_busy(output int n);
      n = 0;
      while (busy_n == 1'b0 && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic read_prefix();
      logic [DATA_W-1:0] d; logic v;
      for (int i = 0; i < 5; i++) host_read(pre[i], d, v);
   endtask

   task automatic expect_quiet(input string req, input int wear_exp);
      for (int i = 0; i < 3; i++) begin
         chk(busy_n == 1'b1, req, busy_n, 1);
         @(negedge clk);
      end
      chk(wear == WEAR_W'(wear_exp), req, wear, wear_exp);
   endtask

   task automatic t_reset();
      chk(busy_n == 1'b1, "R1 reset busy_n", busy_n, 1);
      chk(rvalid == 1'b0, "R1 reset rvalid", rvalid, 0);
      chk(wear == '0, "R1 reset wear", wear, 0);
      chk(standby == 1'b1, "R11 idle standby", standby, 1);
   endtask

   task automatic t_power_up();
      int n;
      pwr_ok = 1'b1;
      @(negedge clk);
      measure_busy(n);
      chk(n == DEPTH, "R3 recall on power restore, R6 length", n, DEPTH);
      chk(wear == '0, "R10 recall leaves wear", wear, 0);
   endtask

   task automatic t_rw();
      logic [DATA_W-1:0] d; logic v;
      host_write(10'd0, 8'h3A);
      host_write(10'd1023, 8'hC5);
      host_write(10'd5, 8'h55);
      host_read(10'd0, d, v);
      chk(v == 1'b1 && d == 8'h3A, "R1 read addr0", d, 8'h3A);
      host_read(10'd1023, d, v);
      chk(v == 1'b1 && d == 8'hC5, "R1 read top", d, 8'hC5);
   endtask

   task automatic t_hw_store();
      logic [DATA_W-1:0] d; logic v; int n;
      store_req_n = 1'b0;
      @(negedge clk);
      store_req_n = 1'b1;
      chk(busy_n == 1'b0, "R4 hw store starts", busy_n, 0);
      chk(standby == 1'b0, "R11 no standby while busy", standby, 0);
      host_write(10'd5, 8'hEE);
      host_read(10'd5, d, v);
      chk(v == 1'b0, "R7 read blocked while busy", v, 0);
      store_req_n = 1'b0;
      @(negedge clk);
      store_req_n = 1'b1;
      measure_busy(n);
      chk(n + 3 == DEPTH, "R6 store length", n + 3, DEPTH);
      expect_quiet("R8 retrigger dropped", 1);
      chk(wear == WEAR_W'(1), "R10 wear after store", wear, 1);
      host_read(10'd5, d, v);
      chk(v == 1'b1 && d == 8'h55, "R7 busy write ignored", d, 8'h55);
   endtask

   task automatic t_sw_recall();
      logic [DATA_W-1:0] d; logic v; int n;
      host_write(10'd0, 8'h00);
      host_write(10'd1023, 8'h00);
      read_prefix();
      host_read(SEL_RECALL, d, v);
      measure_busy(n);
      chk(n == DEPTH, "R5 sw recall runs", n, DEPTH);
      host_read(10'd0, d, v);
      chk(d == 8'h3A, "R4 stored word 0 recalled", d, 8'h3A);
      host_read(10'd1023, d, v);
      chk(d == 8'hC5, "R4 stored top word recalled", d, 8'hC5);
      chk(wear == WEAR_W'(1), "R10 recall no wear", wear, 1);
   endtask

   task automatic t_unlock_breaks();
      logic [DATA_W-1:0] d; logic v;
      read_prefix();
      host_read(10'h001, d, v);
      host_read(SEL_STORE, d, v);
      expect_quiet("R5 stray read resets matcher", 1);
      read_prefix();
      host_write(10'h002, 8'h12);
      host_read(SEL_STORE, d, v);
      expect_quiet("R5 write resets matcher", 1);
   endtask

   task automatic t_sw_store();
      logic [DATA_W-1:0] d; logic v; int n;
      host_write(10'd7, 8'h77);
      read_prefix();
      host_read(SEL_STORE, d, v);
      measure_busy(n);
      chk(n == DEPTH, "R5 sw store runs", n, DEPTH);
      chk(wear == WEAR_W'(2), "R10 wear after sw store", wear, 2);
      host_write(10'd7, 8'h01);
      read_prefix();
      host_read(SEL_RECALL, d, v);
      measure_busy(n);
      host_read(10'd7, d, v);
      chk(d == 8'h77, "R5 sw store captured data", d, 8'h77);
   endtask

   task automatic t_priority();
      logic [DATA_W-1:0] d; logic v; int n;
      host_write(10'd9, 8'h11);
      read_prefix();
      ce = 1'b1; we = 1'b0; addr = SEL_RECALL; store_req_n = 1'b0;
      @(negedge clk);
      ce = 1'b0; store_req_n = 1'b1;
      measure_busy(n);
      chk(n == DEPTH, "R9 collision runs one transfer", n, DEPTH);
      chk(wear == WEAR_W'(3), "R9 store chosen over recall", wear, 3);
      host_read(10'd9, d, v);
      chk(d === 8'h11, "R9 sram not overwritten", d, 8'h11);
   endtask

   task automatic t_power_fail();
      logic [DATA_W-1:0] d; logic v; int n;
      host_write(10'd12, 8'h5C);
      pwr_ok = 1'b0;
      @(negedge clk);
      measure_busy(n);
      chk(n == DEPTH, "R2 power-fail store runs", n, DEPTH);
      chk(wear == WEAR_W'(WEAR_MAX), "R10 wear saturates", wear, WEAR_MAX);
      host_write(10'd12, 8'h00);
      pwr_ok = 1'b1;
      @(negedge clk);
      measure_busy(n);
      chk(n == DEPTH, "R3 recall after restore", n, DEPTH);
      host_read(10'd12, d, v);
      chk(d == 8'h5C, "R2 R3 data survives power cycle", d, 8'h5C);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_power_up();
      t_rw();
      t_hw_store();
      t_sw_recall();
      t_unlock_breaks();
      t_sw_store();
      t_priority();
      t_power_fail();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule